// File: doc/BRIEF.md
# Bounded-Window Response Checker

This block is a synthesizable runtime monitor. It sits beside a design and watches two single-bit signals on every clock edge: a trigger and a response. Each cycle in which the trigger is high creates an obligation that the response must meet within a fixed window of later cycles. When an obligation is broken, the block raises a one-cycle violation pulse and sets a sticky error flag. The flag stays set until reset.

A build-time parameter selects one of three checking rules:

- **Exact delay:** the response must be high exactly N cycles after the trigger.
- **Whole window:** the response must be high on every cycle from the window's first age I through its last age J.
- **Any in window:** one high response anywhere from age I through age J is enough.

Triggers may arrive in back-to-back or nearby cycles, so many obligations can be pending at once. In the any-in-window rule, one response can satisfy all obligations whose windows cover that cycle.

Top module: `resp_window_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `violPulse` and `errSticky` are low until a violation is detected.
- R2: Exact mode (window first = last = `DELAY_N`): a trigger sampled at edge t requires the response high at edge t+N; otherwise `violPulse` is high in the cycle after edge t+N.
- R3: Whole-window mode: a trigger at edge t raises no violation when the response is high at every edge t+I through t+J.
- R4: Whole-window mode: every edge at which the response is low while some obligation has age I..J causes `violPulse` high in the following cycle. The first low edge in a window is therefore reported.
- R5: Any-in-window mode: an obligation from edge t that saw no high response at edges t+I..t+J causes `violPulse` high in the cycle after edge t+J.
- R6: Any-in-window mode: one high response discharges every pending obligation whose window contains that edge. Triggers at t=2 and t=4 with window 3..5 are both met by a single response at edge 7.
- R7: Obligations from different triggers are tracked independently even when their windows overlap.
- R8: A response outside every pending window never causes a violation. An edge with the trigger low imposes no requirement. A high response never produces a violation in the next cycle.
- R9: `errSticky` rises together with the first `violPulse` and stays high until reset.
- R10: Reset discards all pending obligations, so triggers seen before reset cause no violation after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Trigger; high opens an obligation |
| respIn | input | 1 | Response being checked |
| violPulse | output | 1 | High for one cycle after a failing edge |
| errSticky | output | 1 | Set on first violation, cleared by reset |

## Verification
The bench targets three corner cases:

- **Overlapping windows.** Two triggers two cycles apart share cycle 7. A design that let a later trigger overwrite an earlier one would miss the early failure in exact mode. It would also miss the extra low cycles in whole-window mode.
- **A single response in any-in-window mode.** A design that paired responses one-to-one with triggers would wrongly flag the second trigger.
- **Reset with obligations pending, and stray responses.** Stray responses must stay silent. A design that kept stale obligations across reset, or that reported late or early by one cycle, shows up as a pulse in the wrong cycle against the per-cycle expected stream.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

  typedef enum logic [1:0] {
    MODE_EXACT = 2'd0,
    MODE_ALL   = 2'd1,
    MODE_ANY   = 2'd2
  } mode_e;

  // strobes from control to datapath for the current edge
  typedef struct packed {
    logic discharge;  // clear all in-window obligations
    logic violate;    // a rule failed at this edge
  } strobe_t;

endpackage

// File: rtl/rwm_datapath.sv
module rwm_datapath #(
  parameter int LO = 3,
  parameter int HI = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  rwm_pkg::strobe_t stb,
  output logic             inWindow,
  output logic             lastAge,
  output logic             pipeEmpty,
  output logic             violPulse,
  output logic             errSticky
);

  // ageQ[k] high: a trigger seen k edges ago is still pending
  logic [HI:1] ageQ;
  logic [HI:1] ageD;

  assign ageD[1] = trigIn;

  for (genvar k = 2; k <= HI; k++) begin : g_age
    localparam bit PREV_IN_WIN = (k - 1) >= LO;
    if (PREV_IN_WIN) begin : g_clr
      assign ageD[k] = ageQ[k-1] & ~stb.discharge;
    end else begin : g_keep
      assign ageD[k] = ageQ[k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageQ      <= '0;
      violPulse <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      ageQ      <= ageD;
      violPulse <= stb.violate;
      errSticky <= errSticky | stb.violate;
    end
  end

  assign inWindow  = |ageQ[HI:LO];
  assign lastAge   = ageQ[HI];
  assign pipeEmpty = (ageQ == '0);

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);  // R9

  AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> errSticky);  // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    pipeEmpty |=> !violPulse);  // R8

endmodule

// File: rtl/rwm_control.sv
module rwm_control #(
  parameter rwm_pkg::mode_e MODE = rwm_pkg::MODE_ANY
) (
  input  logic             respIn,
  input  logic             inWindow,
  input  logic             lastAge,
  output rwm_pkg::strobe_t stb
);

  localparam bit IS_ANY = (MODE == rwm_pkg::MODE_ANY);

  always_comb begin
    stb = '0;
    if (IS_ANY) begin
      stb.discharge = respIn & inWindow;
      stb.violate   = lastAge & ~respIn;
    end else begin
      stb.discharge = 1'b0;
      stb.violate   = inWindow & ~respIn;
    end
  end

  always_comb begin
    AST_NO_DISCHARGE_FIXED: assert (IS_ANY || !stb.discharge);  // R3
  end

endmodule

// File: rtl/resp_window_monitor.sv
module resp_window_monitor #(
  parameter rwm_pkg::mode_e MODE = rwm_pkg::MODE_ANY,
  parameter int DELAY_N   = 3,
  parameter int WIN_FIRST = 3,
  parameter int WIN_LAST  = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigIn,
  input  logic respIn,
  output logic violPulse,
  output logic errSticky
);

  localparam bit IS_EXACT = (MODE == rwm_pkg::MODE_EXACT);
  localparam int LO = IS_EXACT ? DELAY_N : WIN_FIRST;
  localparam int HI = IS_EXACT ? DELAY_N : WIN_LAST;

  rwm_pkg::strobe_t stb;
  logic inWindow;
  logic lastAge;
  logic pipeEmpty;

  rwm_control #(.MODE(MODE)) i_ctrl (
    .respIn  (respIn),
    .inWindow(inWindow),
    .lastAge (lastAge),
    .stb     (stb)
  );

  rwm_datapath #(.LO(LO), .HI(HI)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .stb      (stb),
    .inWindow (inWindow),
    .lastAge  (lastAge),
    .pipeEmpty(pipeEmpty),
    .violPulse(violPulse),
    .errSticky(errSticky)
  );

  AST_RESP_NO_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    respIn |=> !violPulse);  // R8

endmodule

// File: tb/test_resp_window_monitor.sv
module test_resp_window_monitor;

  localparam int I = 3;
  localparam int J = 5;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic respIn = 1'b0;
  logic vAny, sAny, vAll, sAll, vEx, sEx;

  always #5 clk = ~clk;

  resp_window_monitor #(.MODE(rwm_pkg::MODE_ANY), .WIN_FIRST(I), .WIN_LAST(J)) i_resp_window_monitor (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .respIn(respIn), .violPulse(vAny), .errSticky(sAny));
  resp_window_monitor #(.MODE(rwm_pkg::MODE_ALL), .WIN_FIRST(I), .WIN_LAST(J)) i_resp_window_monitor_all (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .respIn(respIn), .violPulse(vAll), .errSticky(sAll));
  resp_window_monitor #(.MODE(rwm_pkg::MODE_EXACT), .DELAY_N(N)) i_resp_window_monitor_exact (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .respIn(respIn), .violPulse(vEx), .errSticky(sEx));

  typedef struct {
    string req;
    bit eAny, eAll, eEx;
    bit kAny, kAll, kEx;
  } item_t;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit trigV[64];
  bit respV[64];
  bit stAny, stAll, stEx;
  int seed = 7;

  task automatic check(bit act, bit exp, string req, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit expExact(int c);
    return (c - N >= 0) && trigV[c-N] && !respV[c];
  endfunction

  function automatic bit expAll(int c);
    for (int d = I; d <= J; d++)
      if (c - d >= 0 && trigV[c-d] && !respV[c]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit expAny(int c);
    int t = c - J;
    if (t < 0 || !trigV[t]) return 1'b0;
    for (int e = t + I; e <= t + J; e++)
      if (respV[e]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic clearVec();
    for (int c = 0; c < 64; c++) begin
      trigV[c] = 1'b0;
      respV[c] = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; trigIn = 1'b0; respIn = 1'b0;
    repeat (2) @(negedge clk);
    check(vAny, 1'b0, "R1,R10", "any pulse in reset");
    check(sAny | sAll | sEx, 1'b0, "R1,R10", "sticky in reset");
    check(vAll | vEx, 1'b0, "R1", "all/exact pulse in reset");
    rstN = 1'b1;
    stAny = 0; stAll = 0; stEx = 0;
  endtask

  // driver: applies one scenario and pushes per-edge expectations
  task automatic runScenario(string req, int n);
    for (int c = 0; c < n; c++) begin
      item_t it;
      @(negedge clk);
      trigIn = trigV[c];
      respIn = respV[c];
      it.req = req;
      it.eAny = expAny(c);
      it.eAll = expAll(c);
      it.eEx  = expExact(c);
      stAny |= it.eAny; stAll |= it.eAll; stEx |= it.eEx;
      it.kAny = stAny; it.kAll = stAll; it.kEx = stEx;
      expQ.push_back(it);
    end
    @(negedge clk);
    trigIn = 1'b0;
    respIn = 1'b0;
    wait (expQ.size() == 0);
  endtask

  // monitor: samples just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(vAny, it.eAny, it.req, "any-mode pulse");
        check(vAll, it.eAll, it.req, "all-mode pulse");
        check(vEx,  it.eEx,  it.req, "exact-mode pulse");
        check(sAny, it.kAny, it.req, "R9 any sticky");
        check(sAll, it.kAll, it.req, "R9 all sticky");
        check(sEx,  it.kEx,  it.req, "R9 exact sticky");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    doReset();

    // R3: every window cycle high; R7 overlap satisfied
    clearVec();
    trigV[2] = 1; trigV[4] = 1;
    for (int c = 5; c <= 9; c++) respV[c] = 1;
    runScenario("R3,R7", 14);
    doReset();

    // R6: one response at 7 meets triggers at 2 and 4 in any mode
    clearVec();
    trigV[2] = 1; trigV[4] = 1; respV[7] = 1;
    runScenario("R6,R7,R4,R2", 14);
    doReset();

    // R4,R5: no response at all
    clearVec();
    trigV[2] = 1;
    runScenario("R4,R5", 12);
    doReset();

    // R2: exact hit at t+N only
    clearVec();
    trigV[3] = 1; respV[6] = 1;
    runScenario("R2,R4", 12);
    doReset();

    // R8: stray responses and idle trigger
    clearVec();
    for (int c = 0; c < 20; c++) respV[c] = (c % 3 == 0);
    runScenario("R8", 20);
    doReset();

    // R10: leave obligations pending, reset, then observe silence
    clearVec();
    trigV[4] = 1; trigV[5] = 1;
    runScenario("R10", 6);
    doReset();
    clearVec();
    runScenario("R10", 12);
    doReset();

    // R7: pseudo-random mix
    clearVec();
    for (int c = 0; c < 60; c++) begin
      seed = seed * 1103515245 + 12345;
      trigV[c] = (seed[17:16] == 2'b00);
      respV[c] = seed[20];
    end
    runScenario("R7", 60);
    doReset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule